// File: doc/BRIEF.md
# Manchester HDLC Line Receiver

This block recovers HDLC octets from one Manchester-coded serial line. The line is sampled on every system clock. The block measures how long each level holds, and from that length it works out how many half-bit cells the level spanned. The nominal cell length comes from a programmable tick count. The half-bits are paired into data bits. A pair that cannot be legal Manchester makes the local phase slip by one half-bit, so the block can lock onto either starting edge.

After a run of clean bits, the block searches the bit stream for the HDLC flag. The flag sets the octet boundary. Stuffed zeros are removed, and each flag or data octet leaves the block as a 16-bit word with a tag. Each word carries a type nibble and a channel nibble taken from a static input. Address filtering, frame checking and host transfer are done downstream.

The output is a valid/ready stream with a single holding register. A word that has been offered stays on the port, unchanged, until the consumer accepts it. If a new word is produced while the register is still held, the new word is discarded. A consumer that keeps ready low for longer than about one octet time will therefore lose words.

Top module: `manchester_hdlc_rx`

## Requirements
- R1: After reset, `out_valid` is low. No word is produced until a flag has been recognised.
- R2: Let H be `half_ticks`. A level that held for fewer than 1.5·H samples counts as one half-bit. A level that held for fewer than 2.5·H samples counts as two half-bits. A level that holds 2.5·H samples or more is a line error. Timing jitter of ±1 sample on each cell is tolerated.
- R3: A half-bit pair 1 then 0 decodes as data bit 1. A pair 0 then 1 decodes as data bit 0. Octets are assembled least significant bit first.
- R4: A pair 00 or 11 is an error, and the second half-bit becomes the first half of the next pair. Every error, whether from a bad pair or a long run, clears the clean-bit count, the octet alignment and the frame state.
- R5: Bits are passed to flag search only after 8 consecutive error-free bits have been decoded. Bits decoded before that are discarded.
- R6: The sequence 0, six 1s, 0 is a flag. It yields the word {4'b1111, chan_id, 8'h7E} and restarts the octet boundary.
- R7: A data octet yields {4'b0000, chan_id, octet}. This happens only when a flag has been seen since the last error or abort.
- R8: A 0 that follows five consecutive 1s is removed from the data. It does not count toward the octet.
- R9: Seven consecutive 1s abort the frame. No data word is produced until the next flag.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R11: `half_ticks` sets the cell length. The receiver decodes correctly at different settings, for example 8 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the line is sampled on every rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Manchester-coded serial line |
| half_ticks | input | CNT_W | Samples per half-bit cell (4 or more) |
| chan_id | input | 4 | Channel number placed in bits [11:8] of each word |
| out_valid | output | 1 | A tagged word is offered |
| out_ready | input | 1 | The consumer accepts the offered word |
| out_data | output | 16 | Tag [15:12], channel [11:8], octet [7:0] |

## Verification
The bench runs a stream of back-to-back frames, with cell lengths jittered by ±1 sample. The frames include octets that need stuffing, such as 0xFF, 0x7E and 0x1F. A destuffer that counts ones across the wrong boundary would corrupt exactly these octets or split them. One frame is aborted by raw all-ones. A receiver that does not clear the frame state on seven 1s would emit the octets that follow the abort.

A long idle gap forces a line error, and a new frame starts at once after it. The opening flag of that frame falls inside the clean-bit window. A design that searches for flags too early, or that keeps its frame state across an error, would emit the octet that follows that flag. The run ends with a reset at a shorter cell length and a new channel number. This exposes fixed thresholds and a stale channel field.

// File: rtl/manchester_hdlc_pkg.sv
package manchester_hdlc_pkg;
  localparam logic [3:0] TAG_FLAG = 4'hF;
  localparam logic [3:0] TAG_DATA = 4'h0;
  localparam logic [7:0] FLAG_OCTET = 8'h7E;

  typedef struct packed {
    logic [3:0] tag;
    logic [3:0] chan;
    logic [7:0] body;
  } rx_word_t;

  function automatic rx_word_t make_word(input logic [3:0] tag, input logic [3:0] chan,
                                         input logic [7:0] body);
    rx_word_t w;
    w.tag  = tag;
    w.chan = chan;
    w.body = body;
    return w;
  endfunction
endpackage

// File: rtl/mhr_run_track.sv
// Samples the line, measures each run of a level and converts it into
// one or two half-bit cells (R2). Over-long runs are flagged as errors.
module mhr_run_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic [CNT_W-1:0] half_ticks,
  output logic             half_vld,
  output logic             half_val,
  output logic             run_err
);
  localparam int RUN_W = CNT_W + 2;
  localparam int LIM_W = CNT_W + 3;

  logic             sync1, sync2, level, long_run, pend, pend_val;
  logic [RUN_W-1:0] run;
  logic [LIM_W-1:0] run_x2, lim_one, lim_two;
  logic             edge_seen;

  always_comb begin
    run_x2    = {run, 1'b0};
    lim_one   = {3'b000, half_ticks} + {2'b00, half_ticks, 1'b0};
    lim_two   = lim_one + {2'b00, half_ticks, 1'b0};
    edge_seen = (sync2 != level);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      level    <= 1'b0;
      run      <= '0;
      long_run <= 1'b0;
      pend     <= 1'b0;
      pend_val <= 1'b0;
      half_vld <= 1'b0;
      half_val <= 1'b0;
      run_err  <= 1'b0;
    end else begin
      sync1    <= line_in;
      sync2    <= sync1;
      half_vld <= 1'b0;
      run_err  <= 1'b0;
      if (edge_seen) begin
        level    <= sync2;
        run      <= RUN_W'(1);
        long_run <= 1'b0;
        if (pend) begin
          pend    <= 1'b0;
          run_err <= 1'b1;
        end else if (!long_run) begin
          if (run_x2 < lim_one) begin
            half_vld <= 1'b1;
            half_val <= level;
          end else if (run_x2 < lim_two) begin
            half_vld <= 1'b1;
            half_val <= level;
            pend     <= 1'b1;
            pend_val <= level;
          end else begin
            run_err <= 1'b1;
          end
        end
      end else begin
        if (run != '1) run <= run + RUN_W'(1);
        if (pend) begin
          half_vld <= 1'b1;
          half_val <= pend_val;
          pend     <= 1'b0;
        end
        if (!long_run && (run_x2 >= lim_two)) begin
          long_run <= 1'b1;
          run_err  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mhr_phase_align.sv
// Pairs half-bits into data bits (R3), slips one half-bit on an illegal
// pair (R4) and releases bits only after a clean run (R5).
module mhr_phase_align #(
  parameter int CLEAN_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_vld,
  input  logic half_val,
  input  logic run_err,
  output logic bit_vld,
  output logic bit_val,
  output logic man_err
);
  localparam int CW = $clog2(CLEAN_BITS + 1);

  logic          have_first, first_val;
  logic [CW-1:0] clean_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_first <= 1'b0;
      first_val  <= 1'b0;
      clean_cnt  <= '0;
      bit_vld    <= 1'b0;
      bit_val    <= 1'b0;
      man_err    <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      man_err <= 1'b0;
      if (run_err) begin
        have_first <= 1'b0;
        clean_cnt  <= '0;
        man_err    <= 1'b1;
      end else if (half_vld) begin
        if (!have_first) begin
          have_first <= 1'b1;
          first_val  <= half_val;
        end else if (first_val == half_val) begin
          man_err   <= 1'b1;
          clean_cnt <= '0;
          first_val <= half_val;
        end else begin
          have_first <= 1'b0;
          if (clean_cnt == CW'(CLEAN_BITS)) begin
            bit_vld <= 1'b1;
            bit_val <= first_val;
          end else begin
            clean_cnt <= clean_cnt + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/mhr_deframer.sv
// Flag search, zero removal, abort handling and octet assembly (R6-R9).
module mhr_deframer
  import manchester_hdlc_pkg::*;
#(
  parameter int OCT_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_vld,
  input  logic     bit_val,
  input  logic     man_err,
  input  logic [3:0] chan_id,
  output logic     word_vld,
  output rx_word_t word
);
  localparam int BC_W = $clog2(OCT_W);

  logic [2:0]       ones;
  logic [BC_W-1:0]  bit_cnt;
  logic [OCT_W-1:0] octet;
  logic [OCT_W-1:0] octet_next;
  logic             flag_seen;

  assign octet_next = {bit_val, octet[OCT_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones      <= '0;
      bit_cnt   <= '0;
      octet     <= '0;
      flag_seen <= 1'b0;
      word_vld  <= 1'b0;
      word      <= '0;
    end else begin
      word_vld <= 1'b0;
      if (man_err) begin
        ones      <= '0;
        bit_cnt   <= '0;
        flag_seen <= 1'b0;
      end else if (bit_vld) begin
        if (bit_val) begin
          if (ones != 3'd7) ones <= ones + 3'd1;
          octet   <= octet_next;
          bit_cnt <= bit_cnt + BC_W'(1);
          if (ones == 3'd6) begin
            flag_seen <= 1'b0;
          end else if (bit_cnt == BC_W'(OCT_W - 1) && flag_seen) begin
            word_vld <= 1'b1;
            word     <= make_word(TAG_DATA, chan_id, octet_next);
          end
        end else if (ones == 3'd5) begin
          ones <= '0;
        end else if (ones == 3'd6) begin
          ones      <= '0;
          bit_cnt   <= '0;
          flag_seen <= 1'b1;
          word_vld  <= 1'b1;
          word      <= make_word(TAG_FLAG, chan_id, FLAG_OCTET);
        end else begin
          ones    <= '0;
          octet   <= octet_next;
          bit_cnt <= bit_cnt + BC_W'(1);
          if (bit_cnt == BC_W'(OCT_W - 1) && flag_seen) begin
            word_vld <= 1'b1;
            word     <= make_word(TAG_DATA, chan_id, octet_next);
          end
        end
      end
    end
  end
endmodule

// File: rtl/manchester_hdlc_rx.sv
module manchester_hdlc_rx
  import manchester_hdlc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int CLEAN_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic [CNT_W-1:0] half_ticks,
  input  logic [3:0]       chan_id,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [15:0]      out_data
);
  logic     half_vld, half_val, run_err;
  logic     bit_vld, bit_val, man_err;
  logic     word_vld;
  rx_word_t word;

  mhr_run_track #(.CNT_W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .half_ticks(half_ticks),
    .half_vld(half_vld), .half_val(half_val), .run_err(run_err)
  );

  mhr_phase_align #(.CLEAN_BITS(CLEAN_BITS)) u_align (
    .clk(clk), .rst_n(rst_n), .half_vld(half_vld), .half_val(half_val),
    .run_err(run_err), .bit_vld(bit_vld), .bit_val(bit_val), .man_err(man_err)
  );

  mhr_deframer #(.OCT_W(8)) u_defr (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .man_err(man_err), .chan_id(chan_id), .word_vld(word_vld), .word(word)
  );

  // One holding register; a word arriving while it is held is dropped (R10).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (word_vld && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_data  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/manchester_hdlc_rx_chk.sv
module manchester_hdlc_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  chan_id,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_tag_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[15:12] == 4'hF || out_data[15:12] == 4'h0));

  p_chan_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[11:8] == chan_id));

  p_flag_body_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[15:12] == 4'hF) |-> (out_data[7:0] == 8'h7E));

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

bind manchester_hdlc_rx manchester_hdlc_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_id(chan_id),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/manchester_hdlc_rx_bench.sv
`timescale 1ns/1ps
module manchester_hdlc_rx_bench;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line_in = 1'b0;
  logic [CNT_W-1:0] half_ticks = CNT_W'(8);
  logic [3:0]       chan_id = 4'hA;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [15:0]      out_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit synced = 1'b0;
  bit hold_pend = 1'b0;
  logic [15:0] hold_data = '0;
  int tx_ones = 0;
  int bitq[$];
  logic [15:0] exp_q[$];
  logic [7:0] fr[$];

  always #10 clk = ~clk;

  manchester_hdlc_rx #(.CNT_W(CNT_W)) u_manchester_hdlc_rx (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .half_ticks(half_ticks),
    .chan_id(chan_id), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial begin
    forever begin
      @(posedge clk);
      #2 out_ready = (($urandom % 10) < 7);
    end
  end

  // Stream monitor: skips leading flags while hunting, then compares in order.
  always @(negedge clk) begin
    if (!rst_n) begin
      hold_pend = 1'b0;
    end else begin
      if (hold_pend) begin
        checks++;
        if (!(out_valid && out_data == hold_data)) begin
          fails++;
          $display("FAIL R10 held word changed: valid=%0b data=%h expected %h", out_valid, out_data, hold_data);
        end
      end
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
      if (out_valid && out_ready) begin
        if (synced || out_data[15:12] != 4'hF) begin
          synced = 1'b1;
          checks++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R7 unexpected word: got %h expected none", out_data);
          end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            // R3 and R8 show up as wrong octet values in data words
            if (out_data !== e) begin
              fails++;
              if (e[15:12] == 4'hF) $display("FAIL R6 flag word: got %h expected %h", out_data, e);
              else $display("FAIL R7 data word: got %h expected %h", out_data, e);
            end
          end
        end
      end
    end
  end

  task automatic push_flag();
    bitq.push_back(0);
    for (int i = 0; i < 6; i++) bitq.push_back(1);
    bitq.push_back(0);
    tx_ones = 0;
  endtask

  // R8: the stuffed encoder inserts a 0 after five 1s; octets go LSB first (R3)
  task automatic push_octet(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      bitq.push_back(int'(b[i]));
      if (b[i]) begin
        tx_ones++;
        if (tx_ones == 5) begin
          bitq.push_back(0);
          tx_ones = 0;
        end
      end else begin
        tx_ones = 0;
      end
    end
  endtask

  task automatic push_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bitq.push_back(int'(b[i]));
    tx_ones = 0;
  endtask

  function automatic logic [15:0] flag_word(input logic [3:0] ch);
    return {4'hF, ch, 8'h7E};
  endfunction

  function automatic logic [15:0] data_word(input logic [3:0] ch, input logic [7:0] b);
    return {4'h0, ch, b};
  endfunction

  task automatic send_frame(input bit open_exp);
    push_flag();
    if (open_exp) exp_q.push_back(flag_word(chan_id));
    foreach (fr[i]) begin
      push_octet(fr[i]);
      exp_q.push_back(data_word(chan_id, fr[i]));
    end
    push_flag();
    exp_q.push_back(flag_word(chan_id));
    fr.delete();
  endtask

  task automatic hold_line(input logic v, input int n);
    line_in = v;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drive_all(input int h, input bit jit);
    int d;
    while (bitq.size() > 0) begin
      int b;
      b = bitq.pop_front();
      if (b == 2) begin
        hold_line(1'b0, 30 * h);
      end else begin
        d = jit ? (h - 1 + int'($urandom % 3)) : h;
        hold_line(b[0], d);
        d = jit ? (h - 1 + int'($urandom % 3)) : h;
        hold_line(~b[0], d);
      end
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    line_in = 1'b0;
    synced = 1'b0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 out_valid after reset: got %0b expected 0", out_valid);
    end
    @(posedge clk);
    #2;
  endtask

  task automatic end_phase(input string tag);
    repeat (300) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s words missing: got %0d left expected 0", tag, exp_q.size());
    end
    exp_q.delete();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // Phase 1: H=8 with jitter on every cell (R2, R11)
    half_ticks = CNT_W'(8);
    chan_id = 4'hA;
    apply_reset();
    for (int i = 0; i < 6; i++) push_flag();
    // stuffing corner octets (R8)
    fr.push_back(8'hFF); fr.push_back(8'h7E); fr.push_back(8'h1F);
    send_frame(1'b0);
    for (int i = 0; i < 5; i++) fr.push_back(8'($urandom));
    send_frame(1'b1);
    // R9: abort by raw all-ones; octets after it are suppressed
    push_flag(); exp_q.push_back(flag_word(chan_id));
    push_octet(8'hA5); exp_q.push_back(data_word(chan_id, 8'hA5));
    push_raw(8'hFF); push_raw(8'h00);
    push_flag(); exp_q.push_back(flag_word(chan_id));
    // R4 and R5: idle gap error, then a flag inside the clean window is missed,
    // so the following octet is not emitted; the closing flag is.
    bitq.push_back(2);
    push_flag();
    push_octet(8'h00);
    push_flag(); exp_q.push_back(flag_word(chan_id));
    for (int i = 0; i < 4; i++) fr.push_back(8'($urandom));
    send_frame(1'b1);
    push_flag(); exp_q.push_back(flag_word(chan_id));
    push_flag();
    drive_all(8, 1'b1);
    end_phase("R4");

    // Phase 2: R11 shorter cell length and another channel
    half_ticks = CNT_W'(5);
    chan_id = 4'h3;
    apply_reset();
    for (int i = 0; i < 6; i++) push_flag();
    for (int i = 0; i < 6; i++) fr.push_back(8'($urandom));
    send_frame(1'b0);
    push_flag(); exp_q.push_back(flag_word(chan_id));
    push_flag();
    drive_all(5, 1'b0);
    end_phase("R11");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule